// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Status

This block holds received characters for a serial controller in a short first-in, first-out queue. It is three entries deep by default. Each entry stores the character together with three flags: a framing or check-sum failure, a parity failure, and an overrun tag. The host sees the oldest entry. A read strobe removes that entry and brings the next one forward, along with that entry's flags.

The status view combines per-entry flags with two latches, and each error bit follows its own rule:

- **Framing/check-sum flag:** never latched. It only describes the character at the head.
- **Overrun:** tagged onto the single entry that was overwritten. It latches once the host reads that entry.
- **Parity:** kept set from the moment the failing character reaches the head.

An error-reset strobe clears all three bits.

The interrupt request depends on a special-condition controller with two states:

- **`SRC_CLEAR`:** no special condition is held.
- **`SRC_HELD`:** entered when the host reads an overrun entry, or reads a parity-failing entry while parity counts as a special condition. Every later character then requests an interrupt until the error-reset strobe returns the controller to `SRC_CLEAR`.

Queue occupancy is tracked by a second machine with three states:

- **`OCC_EMPTY`:** the queue holds nothing.
- **`OCC_PART`:** the queue holds some entries but is not full.
- **`OCC_FULL`:** every entry is in use.

Its transitions are:

- **fill-first:** `OCC_EMPTY` to `OCC_PART` on a write.
- **fill-last:** `OCC_PART` to `OCC_FULL` when a write without a read takes the last free entry.
- **drain-first:** `OCC_FULL` to `OCC_PART` on a read without a write.
- **drain-last:** `OCC_PART` to `OCC_EMPTY` when a read without a write takes the only entry.

Every other input combination keeps the current state. That includes an overwrite while full and a read together with a write.

Top module: `rxq_status_fifo`

## Requirements
- R1: Characters leave in arrival order. `rd_avail` is 1 exactly when at least one entry is held. `rd_char` shows the oldest entry one cycle after the write edge, and up to `DEPTH` (default 3) characters are held without loss.
- R2: `st_fcrc` equals the framing/check-sum flag of the head entry, with no latching. It is 0 whenever the queue is empty, and it changes as soon as a read brings another entry to the head.
- R3: A head entry with the framing/check-sum flag requests an interrupt only when `sync_mode` is 0 (asynchronous). With `sync_mode` 1 (synchronous/SDLC) the same flag never requests an interrupt.
- R4: A write while the queue is full and no read occurs replaces the newest entry and tags only that entry as overrun. Older entries keep overrun 0.
- R5: `st_ovr` is 1 while an overrun-tagged entry is at the head. Once the host reads that entry, `st_ovr` stays 1 until the error reset or `rst`.
- R6: After an overrun entry is read, every later character at the head raises `irq` (with `rx_irq_en` 1) until the error reset.
- R7: `st_par` is 1 while a parity-failing entry is at the head. After that entry is read, `st_par` stays 1 until the error reset or `rst`.
- R8: With `par_spec_en` 1, a parity-failing head entry raises `irq`, and after it is read every later character raises `irq` until the error reset. With `par_spec_en` 0, parity failures never raise `irq`.
- R9: `err_rst` for one cycle clears `st_fcrc`, `st_ovr` and `st_par`, clears the held special condition, and removes no entry.
- R10: A read and a write in the same cycle on a non-empty queue both take effect, with occupancy unchanged and no overrun tag. A read on an empty queue changes nothing, and `rd_char` keeps the last character read.
- R11: Synchronous `rst` empties the queue and clears both latches and the held condition. This drives `rd_avail`, `irq`, `st_fcrc`, `st_ovr` and `st_par` to 0.
- R12: `irq` is 1 only while `rx_irq_en` is 1 and a character is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | A received character is presented this cycle |
| wr_char | input | DATA_W | Received character |
| wr_fcrc_err | input | 1 | Framing failure (asynchronous) or check-sum mismatch (synchronous) for `wr_char` |
| wr_par_err | input | 1 | Parity failure for `wr_char` |
| rd_en | input | 1 | Host read: remove the head entry |
| err_rst | input | 1 | Error-reset command strobe |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous/SDLC |
| rx_irq_en | input | 1 | Receive interrupts enabled |
| par_spec_en | input | 1 | Parity failure counts as a special receive condition |
| rd_char | output | DATA_W | Head character, or the last character read when empty |
| rd_avail | output | 1 | At least one character held |
| st_fcrc | output | 1 | Framing/check-sum status of the head entry |
| st_ovr | output | 1 | Overrun status |
| st_par | output | 1 | Parity status |
| irq | output | 1 | Special-receive-condition interrupt request |

## Verification
Some properties are checked on every cycle:

- The interrupt is never raised without a waiting character and the enable.
- The interrupt stays silent in synchronous mode unless an overrun or parity bit is visible.
- The overrun and parity bits stay set until an error reset.
- An error reset with no concurrent read or write clears all status.
- A read of an empty queue leaves data and status untouched.
- A write always leaves a character available.

The bench scenarios are needed for the rest:

- arrival order;
- overrun tagging of only the overwritten entry;
- the repeated interrupt on later characters after an overrun or parity failure;
- mode-dependent treatment of the framing flag;
- a simultaneous read and write on a full queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_FULL
    } occ_state_e;

    typedef enum logic {
        SRC_CLEAR,
        SRC_HELD
    } src_state_e;

    typedef struct packed {
        logic fcrc;
        logic par;
        logic ovr;
    } rx_flags_t;

endpackage

// File: rtl/rxq_ctrl.sv
// Occupancy controller: head pointer, count, and the write slot choice
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             avail,
    output logic             push,
    output logic             pop,
    output logic             overwrite,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] hd_idx
);

    localparam int SUM_W = PTR_W + CNT_W + 1;
    localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

    occ_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] hd_q, hd_d;
    logic             full;
    logic [SUM_W-1:0] sum_tail, sum_last, sum_next;

    function automatic logic [PTR_W-1:0] wrap_idx(input logic [SUM_W-1:0] s);
        if (s >= DEPTH_S) begin
            return PTR_W'(s - DEPTH_S);
        end
        return PTR_W'(s);
    endfunction

    assign sum_tail = SUM_W'(hd_q) + SUM_W'(cnt_q);
    assign sum_last = SUM_W'(hd_q) + SUM_W'(DEPTH - 1);
    assign sum_next = SUM_W'(hd_q) + SUM_W'(1);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
            hd_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hd_q    <= hd_d;
        end
    end

    // outputs
    always_comb begin
        avail     = (state_q != OCC_EMPTY);
        full      = (state_q == OCC_FULL);
        push      = wr_en;
        pop       = rd_en & avail;
        overwrite = wr_en & full & ~pop;
        wr_idx    = overwrite ? wrap_idx(sum_last) : wrap_idx(sum_tail);
        hd_idx    = hd_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hd_d    = pop ? wrap_idx(sum_next) : hd_q;
        if (push && !overwrite && !pop) begin
            cnt_d = cnt_q + ONE_CNT;
        end else if (pop && !push) begin
            cnt_d = cnt_q - ONE_CNT;
        end
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) begin
                    state_d = OCC_PART;                 // fill-first
                end
            end
            OCC_PART: begin
                if (pop && !push && cnt_q == ONE_CNT) begin
                    state_d = OCC_EMPTY;                // drain-last
                end else if (push && !pop && cnt_q == LAST_CNT) begin
                    state_d = OCC_FULL;                 // fill-last
                end
            end
            OCC_FULL: begin
                if (pop && !push) begin
                    state_d = OCC_PART;                 // drain-first
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

endmodule

// File: rtl/rxq_store.sv
// Entry storage: one register slot per queue position
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 3,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_char,
    input  rx_flags_t         wr_flags,
    input  logic              pop,
    input  logic              clr_head,
    input  logic [PTR_W-1:0]  hd_idx,
    output logic [DATA_W-1:0] head_char,
    output rx_flags_t         head_flags,
    output logic [DATA_W-1:0] last_char
);

    logic [DATA_W-1:0] slot_char  [DEPTH];
    rx_flags_t         slot_flags [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] ch_q;
        rx_flags_t         fl_q;
        logic              sel_wr, sel_hd;

        assign sel_wr = push && (wr_idx == PTR_W'(i));
        assign sel_hd = clr_head && (hd_idx == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ch_q <= '0;
                fl_q <= '0;
            end else if (sel_wr) begin
                ch_q <= wr_char;
                fl_q <= wr_flags;
            end else if (sel_hd) begin
                fl_q <= '0;
            end
        end

        assign slot_char[i]  = ch_q;
        assign slot_flags[i] = fl_q;
    end

    always_comb begin
        head_char  = '0;
        head_flags = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (hd_idx == PTR_W'(k)) begin
                head_char  = slot_char[k];
                head_flags = slot_flags[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_char <= '0;
        end else if (pop) begin
            last_char <= head_char;
        end
    end

endmodule

// File: rtl/rxq_err.sv
// Status latches and the special-receive-condition controller
module rxq_err
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      avail,
    input  logic      pop,
    input  rx_flags_t head_flags,
    input  logic      err_rst,
    input  logic      sync_mode,
    input  logic      rx_irq_en,
    input  logic      par_spec_en,
    output logic      st_fcrc,
    output logic      st_ovr,
    output logic      st_par,
    output logic      irq
);

    src_state_e state_q, state_d;
    logic ovr_lat_q, ovr_lat_d;
    logic par_lat_q, par_lat_d;
    logic head_special;
    logic pop_special;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SRC_CLEAR;
            ovr_lat_q <= 1'b0;
            par_lat_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ovr_lat_q <= ovr_lat_d;
            par_lat_q <= par_lat_d;
        end
    end

    // next state
    always_comb begin
        pop_special = pop & (head_flags.ovr | (par_spec_en & head_flags.par));
        ovr_lat_d   = err_rst ? 1'b0 : (ovr_lat_q | (pop & head_flags.ovr));
        par_lat_d   = err_rst ? 1'b0 : (par_lat_q | (pop & head_flags.par));
        state_d     = state_q;
        unique case (state_q)
            SRC_CLEAR: begin
                if (pop_special && !err_rst) begin
                    state_d = SRC_HELD;                 // hold-on-read
                end
            end
            SRC_HELD: begin
                if (err_rst) begin
                    state_d = SRC_CLEAR;                // release-on-reset
                end
            end
            default: state_d = SRC_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        head_special = head_flags.ovr
                     | (par_spec_en & head_flags.par)
                     | (~sync_mode & head_flags.fcrc);
        st_fcrc = avail & head_flags.fcrc;
        st_ovr  = ovr_lat_q | (avail & head_flags.ovr);
        st_par  = par_lat_q | (avail & head_flags.par);
        irq     = rx_irq_en & avail & ((state_q == SRC_HELD) | head_special);
    end

endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_char,
    input  logic              wr_fcrc_err,
    input  logic              wr_par_err,
    input  logic              rd_en,
    input  logic              err_rst,
    input  logic              sync_mode,
    input  logic              rx_irq_en,
    input  logic              par_spec_en,
    output logic [DATA_W-1:0] rd_char,
    output logic              rd_avail,
    output logic              st_fcrc,
    output logic              st_ovr,
    output logic              st_par,
    output logic              irq
);

    localparam int PTR_W = $clog2(DEPTH);

    logic              avail, push, pop, overwrite, clr_head;
    logic [PTR_W-1:0]  wr_idx, hd_idx;
    logic [DATA_W-1:0] head_char, last_char;
    rx_flags_t         wr_flags, head_flags;

    assign wr_flags.fcrc = wr_fcrc_err;
    assign wr_flags.par  = wr_par_err;
    assign wr_flags.ovr  = overwrite;
    assign clr_head      = err_rst & avail & ~pop;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .avail     (avail),
        .push      (push),
        .pop       (pop),
        .overwrite (overwrite),
        .wr_idx    (wr_idx),
        .hd_idx    (hd_idx)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .wr_idx     (wr_idx),
        .wr_char    (wr_char),
        .wr_flags   (wr_flags),
        .pop        (pop),
        .clr_head   (clr_head),
        .hd_idx     (hd_idx),
        .head_char  (head_char),
        .head_flags (head_flags),
        .last_char  (last_char)
    );

    rxq_err u_err (
        .clk         (clk),
        .rst         (rst),
        .avail       (avail),
        .pop         (pop),
        .head_flags  (head_flags),
        .err_rst     (err_rst),
        .sync_mode   (sync_mode),
        .rx_irq_en   (rx_irq_en),
        .par_spec_en (par_spec_en),
        .st_fcrc     (st_fcrc),
        .st_ovr      (st_ovr),
        .st_par      (st_par),
        .irq         (irq)
    );

    assign rd_avail = avail;
    assign rd_char  = avail ? head_char : last_char;

endmodule

// File: rtl/rxq_status_fifo_chk.sv
module rxq_status_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              err_rst,
    input logic              sync_mode,
    input logic              rx_irq_en,
    input logic [DATA_W-1:0] rd_char,
    input logic              rd_avail,
    input logic              st_fcrc,
    input logic              st_ovr,
    input logic              st_par,
    input logic              irq
);

    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!rd_avail && !irq && !st_fcrc && !st_ovr && !st_par));

    a_r12_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_avail && rx_irq_en));

    a_r3_sync_crc_quiet: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !st_ovr && !st_par) |-> !irq);

    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_ovr && !err_rst) |=> st_ovr);

    a_r7_par_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_par && !err_rst) |=> st_par);

    a_r9_err_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (err_rst && !wr_en && !rd_en) |=> (!st_fcrc && !st_ovr && !st_par));

    a_r1_write_fills: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_avail);

    a_r10_empty_read_inert: assert property (@(posedge clk) disable iff (rst)
        (!rd_avail && rd_en && !wr_en && !err_rst)
        |=> (!rd_avail && $stable(rd_char) && $stable(st_ovr) && $stable(st_par)));

endmodule

bind rxq_status_fifo rxq_status_fifo_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rxq_status_fifo_tb.sv
module rxq_status_fifo_tb;

    localparam int DW = 8;
    localparam int NV = 30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, wr_fcrc_err = 1'b0, wr_par_err = 1'b0;
    logic [DW-1:0] wr_char = '0;
    logic          rd_en = 1'b0, err_rst = 1'b0;
    logic          sync_mode = 1'b0, rx_irq_en = 1'b1, par_spec_en = 1'b1;
    logic [DW-1:0] rd_char;
    logic          rd_avail, st_fcrc, st_ovr, st_par, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rxq_status_fifo #(.DATA_W(DW), .DEPTH(3)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
        .wr_fcrc_err(wr_fcrc_err), .wr_par_err(wr_par_err), .rd_en(rd_en),
        .err_rst(err_rst), .sync_mode(sync_mode), .rx_irq_en(rx_irq_en),
        .par_spec_en(par_spec_en), .rd_char(rd_char), .rd_avail(rd_avail),
        .st_fcrc(st_fcrc), .st_ovr(st_ovr), .st_par(st_par), .irq(irq)
    );

    // stimulus: {wr, char, fcrc, par, rd, err_rst, sync, irq_en, par_spec}
    function automatic logic [15:0] sv(input logic w, input logic [7:0] c,
        input logic f, input logic p, input logic r, input logic e,
        input logic s, input logic ie, input logic pn);
        return {w, c, f, p, r, e, s, ie, pn};
    endfunction

    // expected: {avail, char, fcrc, ovr, par, irq}; char compared only when avail
    function automatic logic [12:0] ev(input logic a, input logic [7:0] c,
        input logic f, input logic o, input logic p, input logic i);
        return {a, c, f, o, p, i};
    endfunction

    localparam logic [15:0] VSTIM [NV] = '{
        sv(1,8'h11,0,0,0,0,0,1,1), sv(1,8'h22,1,0,0,0,0,1,1),   // R1 R2 order, framing flag
        sv(0,8'h00,0,0,1,0,0,1,1), sv(0,8'h00,0,0,1,0,0,1,1),   // R3 async framing irq
        sv(1,8'h33,1,0,0,0,1,1,1), sv(0,8'h00,0,0,0,1,1,1,1),   // R3 sync quiet, R9
        sv(0,8'h00,0,0,1,0,1,1,1),
        sv(1,8'h44,0,1,0,0,0,1,1), sv(1,8'h55,0,0,0,0,0,1,1),   // R7 R8 parity special
        sv(0,8'h00,0,0,1,0,0,1,1), sv(0,8'h00,0,0,0,1,0,1,1),
        sv(0,8'h00,0,0,1,0,0,1,1),
        sv(1,8'h66,0,1,0,0,0,1,0), sv(0,8'h00,0,0,1,0,0,1,0),   // R7 sticky, R8 no irq
        sv(1,8'h77,0,0,0,0,0,1,0), sv(0,8'h00,0,0,0,1,0,1,0),
        sv(0,8'h00,0,0,1,0,0,1,0),
        sv(1,8'hA1,0,0,0,0,0,1,1), sv(1,8'hA2,0,0,0,0,0,1,1),   // R4 R5 R6 overrun
        sv(1,8'hA3,0,0,0,0,0,1,1), sv(1,8'hA4,0,0,0,0,0,1,1),
        sv(0,8'h00,0,0,1,0,0,1,1), sv(0,8'h00,0,0,1,0,0,1,1),
        sv(0,8'h00,0,0,1,0,0,1,1), sv(1,8'hB1,0,0,0,0,0,1,1),
        sv(0,8'h00,0,0,0,1,0,1,1), sv(1,8'hB2,0,0,1,0,0,1,1),   // R9, R10 rd+wr
        sv(0,8'h00,0,0,1,0,0,1,1),
        sv(1,8'hC1,1,0,0,0,0,0,1), sv(0,8'h00,0,0,1,0,0,0,1)    // R12 irq disabled
    };

    localparam logic [12:0] VEXP [NV] = '{
        ev(1,8'h11,0,0,0,0), ev(1,8'h11,0,0,0,0),
        ev(1,8'h22,1,0,0,1), ev(0,8'h00,0,0,0,0),
        ev(1,8'h33,1,0,0,0), ev(1,8'h33,0,0,0,0),
        ev(0,8'h00,0,0,0,0),
        ev(1,8'h44,0,0,1,1), ev(1,8'h44,0,0,1,1),
        ev(1,8'h55,0,0,1,1), ev(1,8'h55,0,0,0,0),
        ev(0,8'h00,0,0,0,0),
        ev(1,8'h66,0,0,1,0), ev(0,8'h00,0,0,1,0),
        ev(1,8'h77,0,0,1,0), ev(1,8'h77,0,0,0,0),
        ev(0,8'h00,0,0,0,0),
        ev(1,8'hA1,0,0,0,0), ev(1,8'hA1,0,0,0,0),
        ev(1,8'hA1,0,0,0,0), ev(1,8'hA1,0,0,0,0),
        ev(1,8'hA2,0,0,0,0), ev(1,8'hA4,0,1,0,1),
        ev(0,8'h00,0,1,0,0), ev(1,8'hB1,0,1,0,1),
        ev(1,8'hB1,0,0,0,0), ev(1,8'hB2,0,0,0,0),
        ev(0,8'h00,0,0,0,0),
        ev(1,8'hC1,1,0,0,0), ev(0,8'h00,0,0,0,0)
    };

    function automatic string vec_req(input int i);
        if (i < 4)  return "R1/R2/R3";
        if (i < 7)  return "R3/R9";
        if (i < 12) return "R7/R8/R9";
        if (i < 17) return "R7/R8";
        if (i < 28) return "R4/R5/R6/R9/R10";
        return "R12";
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [12:0] e);
        chk(req, "rd_avail", 32'(rd_avail), 32'(e[12]));
        if (e[12]) chk(req, "rd_char", 32'(rd_char), 32'(e[11:4]));
        chk(req, "st_fcrc", 32'(st_fcrc), 32'(e[3]));
        chk(req, "st_ovr",  32'(st_ovr),  32'(e[2]));
        chk(req, "st_par",  32'(st_par),  32'(e[1]));
        chk(req, "irq",     32'(irq),     32'(e[0]));
    endtask

    task automatic cyc(input logic [15:0] s);
        @(negedge clk);
        {wr_en, wr_char, wr_fcrc_err, wr_par_err, rd_en, err_rst,
         sync_mode, rx_irq_en, par_spec_en} = s;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk_all("R11 reset", ev(0,8'h00,0,0,0,0));
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cyc(VSTIM[i]);
            chk_all(vec_req(i), VEXP[i]);
        end

        // R10: read of an empty queue keeps the last character and status
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk("R10 empty read", "rd_char", 32'(rd_char), 32'h0C1);
        chk_all("R10 empty read", ev(0,8'h00,0,0,0,0));

        // R10: read and write together on a full queue
        cyc(sv(1,8'hD1,0,0,0,0,0,1,1));
        cyc(sv(1,8'hD2,0,0,0,0,0,1,1));
        cyc(sv(1,8'hD3,0,0,0,0,0,1,1));
        cyc(sv(1,8'hD4,0,0,1,0,0,1,1));
        chk_all("R10 full rd+wr", ev(1,8'hD2,0,0,0,0));
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk_all("R10 R1 order", ev(1,8'hD3,0,0,0,0));
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk_all("R10 no overrun tag", ev(1,8'hD4,0,0,0,0));
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk_all("R1 drained", ev(0,8'h00,0,0,0,0));

        // R4: two overwrites leave the tag only on the newest entry
        cyc(sv(1,8'hE1,0,0,0,0,0,1,1));
        cyc(sv(1,8'hE2,0,0,0,0,0,1,1));
        cyc(sv(1,8'hE3,0,0,0,0,0,1,1));
        cyc(sv(1,8'hE4,0,0,0,0,0,1,1));
        cyc(sv(1,8'hE5,0,0,0,0,0,1,1));
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk_all("R4 older untagged", ev(1,8'hE2,0,0,0,0));
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk_all("R4 newest tagged", ev(1,8'hE5,0,1,0,1));
        cyc(sv(0,8'h00,0,0,1,0,0,1,1));
        chk_all("R5 latched", ev(0,8'h00,0,1,0,0));

        // R11: mid-run reset clears the latched overrun and held condition
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk_all("R11 mid reset", ev(0,8'h00,0,0,0,0));
        @(negedge clk);
        rst = 1'b0;
        cyc(sv(1,8'hF1,0,0,0,0,0,1,1));
        chk_all("R11 R6 no held irq", ev(1,8'hF1,0,0,0,0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule